// File: doc/BRIEF.md
# Host Parallel Readout Interface

This block hands recorded samples back to a host computer over a parallel port. The host drives a slow, possibly bouncing read strobe and a small command word. Inside the system clock domain both are synchronised. The strobe must hold a new level for a programmable number of system cycles before that level is accepted. The command picks which of three memory groups is enabled and whether the read address is rewound.

Each accepted rising strobe edge in read mode captures the word at the current memory address into an output holding register. In the same step the shared address counter moves forward. The holding register reaches the host through a one-way bus buffer. The buffer drives only while a memory group is selected and floats otherwise. The host normally rewinds the address, picks a group, then strobes once per word.

Top module: `hpr_readout`

## Requirements
- R1: After reset, `mem_addr` is 0, `mem_sel` is 3'b000 and `host_oe` is 0.
- R2: Command bits [1:0] choose the group: 1, 2 and 3 select group 0, 1 and 2, which drive `mem_sel` to 3'b001, 3'b010 and 3'b100. A value of 0 selects no group and leaves read mode.
- R3: `host_oe` is 1 exactly while a group is selected. While it is 0, `host_data` is high-impedance.
- R4: A strobe level counts only after it has been seen for `DEB_CYC` consecutive synchronised samples. A high pulse shorter than that moves neither the address nor the data.
- R5: An accepted rising strobe edge in read mode captures `mem_rdata` at the current address onto `host_data`. The address then rises by one.
- R6: Falling strobe edges, and rising edges while no group is selected, change neither the address nor the captured word.
- R7: Command bit [2] (rewind) clears the address to 0, whatever the group field holds.
- R8: When rewind and an accepted rising edge act in the same cycle, the word at the old address is captured and the address ends at 0.
- R9: The address wraps from its largest value, 2^ADDR_W-1, back to 0 on the next accepted edge.
- R10: Changing the selected group leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Raw read strobe from the host, asynchronous |
| host_cmd | input | 3 | Raw command: [2] rewind, [1:0] group code |
| mem_addr | output | ADDR_W | Read address shared by all groups |
| mem_sel | output | 3 | One-hot, active-high group chip selects |
| mem_rdata | input | DATA_W | Data returned by the selected group |
| host_data | output | DATA_W | Buffered word toward the host, high-impedance when idle |
| host_oe | output | 1 | Buffer enable, high while reading |

## Verification
The case that needs care is a rewind command and an accepted strobe edge landing in the same system cycle. In that cycle the capture path and the address path pull the counter in opposite directions. The bench provokes it by raising the strobe and then counting cycles, so that a one-cycle rewind pulse reaches the decoder on exactly the cycle the debounced edge is issued. It judges the result by requiring the word from the old address on the output and an address of 0, with no increment left over.

// File: rtl/hpr_pkg.sv
package hpr_pkg;

    localparam int CMD_W   = 3;
    localparam int NUM_GRP = 3;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_A    = 2'd1,
        GRP_B    = 2'd2,
        GRP_C    = 2'd3
    } grp_e;

    // raw command layout as seen on the host lines
    typedef struct packed {
        logic rewind;
        grp_e grp;
    } host_cmd_t;

    // decoded command carried through the datapath
    typedef struct packed {
        logic               rd;
        logic               rewind;
        logic [NUM_GRP-1:0] sel;
    } cmd_dec_t;

    function automatic logic [NUM_GRP-1:0] grp_to_sel(input grp_e g);
        logic [NUM_GRP-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (int'(g) == i + 1) s[i] = 1'b1;
        end
        return s;
    endfunction

    function automatic cmd_dec_t decode_cmd(input host_cmd_t c);
        cmd_dec_t d;
        d.sel    = grp_to_sel(c.grp);
        d.rd     = (c.grp != GRP_NONE);
        d.rewind = c.rewind;
        return d;
    endfunction

endpackage

// File: rtl/hpr_sync.sv
module hpr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hpr_debounce.sv
module hpr_debounce #(
    parameter int DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic lvl_out,
    output logic rise
);
    localparam int CNT_W = (DEB_CYC > 2) ? $clog2(DEB_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             stable_q;
    logic             rise_q;
    logic             differs;
    logic             accept;

    assign differs = (lvl_in != stable_q);
    assign accept  = differs && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
            rise_q   <= 1'b0;
        end else begin
            rise_q <= accept && lvl_in;
            if (accept) begin
                stable_q <= lvl_in;
                cnt_q    <= '0;
            end else if (differs) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign lvl_out = stable_q;
    assign rise    = rise_q;
endmodule

// File: rtl/hpr_addr_gen.sv
module hpr_addr_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              rewind,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    // rewind outranks a simultaneous step
    always_ff @(posedge clk) begin
        if (rst || rewind) addr_q <= '0;
        else if (step)     addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
endmodule

// File: rtl/hpr_word_hold.sv
module hpr_word_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (capture) word_q <= din;
    end

    assign dout = word_q;
endmodule

// File: rtl/hpr_readout.sv
module hpr_readout
    import hpr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int DEB_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_strobe,
    input  logic [CMD_W-1:0]  host_cmd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_GRP-1:0] mem_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] host_data,
    output logic              host_oe
);
    logic              strobe_sync;
    logic              strobe_lvl;
    logic              edge_rise;
    logic [CMD_W-1:0]  cmd_sync;
    cmd_dec_t          dec;
    logic              rd_mode;
    logic              rewind_req;
    logic              take_word;
    logic [DATA_W-1:0] held_word;

    hpr_sync #(.W(1), .STAGES(2)) u_strobe_sync (
        .clk(clk), .rst(rst), .d(host_strobe), .q(strobe_sync)
    );

    hpr_sync #(.W(CMD_W), .STAGES(2)) u_cmd_sync (
        .clk(clk), .rst(rst), .d(host_cmd), .q(cmd_sync)
    );

    hpr_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst(rst), .lvl_in(strobe_sync),
        .lvl_out(strobe_lvl), .rise(edge_rise)
    );

    always_comb begin
        dec = decode_cmd(host_cmd_t'(cmd_sync));
    end

    assign rd_mode    = dec.rd;
    assign rewind_req = dec.rewind;
    assign take_word  = edge_rise && rd_mode;

    hpr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .step(take_word), .rewind(rewind_req),
        .addr(mem_addr)
    );

    hpr_word_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .capture(take_word), .din(mem_rdata),
        .dout(held_word)
    );

    assign mem_sel   = dec.sel;
    assign host_oe   = rd_mode;
    assign host_data = host_oe ? held_word : 'z;
endmodule

// File: rtl/hpr_readout_chk.sv
module hpr_readout_chk #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int DEB_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_lvl,
    input logic              deb_lvl,
    input logic              rise,
    input logic              rd_mode,
    input logic              rewind,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        mem_sel,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] word
);
    localparam int RUN_W = $clog2(DEB_CYC + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEB_CYC);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)               run_q <= '0;
        else if (!sync_lvl)    run_q <= '0;
        else if (run_q < RUN_MAX) run_q <= run_q + 1'b1;
    end

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_sel));

    assert_debounce_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(deb_lvl) |-> (run_q >= RUN_MAX));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (rise && rd_mode && !rewind) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (rise && rd_mode) |=> (word == $past(mem_rdata)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!(rise && rd_mode) && !rewind) |=> $stable(mem_addr));

    assert_rewind_R7: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (mem_addr == '0));
endmodule

bind hpr_readout hpr_readout_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEB_CYC(DEB_CYC)
) u_chk (
    .clk(clk), .rst(rst), .sync_lvl(strobe_sync), .deb_lvl(strobe_lvl),
    .rise(edge_rise), .rd_mode(rd_mode), .rewind(rewind_req),
    .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_rdata(mem_rdata),
    .word(held_word)
);

// File: tb/test_hpr_readout.sv
module test_hpr_readout;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int DEB_CYC = 4;
    localparam int SETTLE  = DEB_CYC + 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_strobe = 1'b0;
    logic [2:0]        host_cmd = 3'b000;
    logic [ADDR_W-1:0] mem_addr;
    logic [2:0]        mem_sel;
    logic [DATA_W-1:0] mem_rdata;
    wire  [DATA_W-1:0] host_data;
    logic              host_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpr_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEB_CYC(DEB_CYC)) i_hpr_readout (
        .clk(clk), .rst(rst), .host_strobe(host_strobe), .host_cmd(host_cmd),
        .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_rdata(mem_rdata),
        .host_data(host_data), .host_oe(host_oe)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [1:0] g, input logic [ADDR_W-1:0] a);
        return DATA_W'((int'(g) << 5) + int'(a)) ^ 8'h5A;
    endfunction

    // memory model: three groups, each with its own content
    logic [1:0] mem_grp;
    always_comb begin
        case (mem_sel)
            3'b001:  mem_grp = 2'd1;
            3'b010:  mem_grp = 2'd2;
            3'b100:  mem_grp = 2'd3;
            default: mem_grp = 2'd0;
        endcase
        mem_rdata = pat(mem_grp, mem_addr);
    end

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              oe;
        logic [2:0]        sel;
        string             req;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    logic [ADDR_W-1:0] m_addr = '0;
    logic [DATA_W-1:0] m_data = '0;
    logic [1:0]        m_grp  = 2'd0;

    task automatic push_exp(input string req);
        exp_t e;
        e.addr = m_addr;
        e.data = m_data;
        e.oe   = (m_grp != 2'd0);
        e.sel  = (m_grp == 2'd0) ? 3'b000 : 3'(1 << (m_grp - 1));
        e.req  = req;
        q.push_back(e);
        ->chk_ev;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (mem_addr !== e.addr) begin
                    n_bad++;
                    $display("FAIL %s mem_addr actual=%0d expected=%0d", e.req, mem_addr, e.addr);
                end
                n_cmp++;
                if (mem_sel !== e.sel) begin
                    n_bad++;
                    $display("FAIL %s mem_sel actual=%b expected=%b", e.req, mem_sel, e.sel);
                end
                n_cmp++;
                if (host_oe !== e.oe) begin
                    n_bad++;
                    $display("FAIL %s host_oe actual=%b expected=%b", e.req, host_oe, e.oe);
                end
                if (e.oe) begin
                    n_cmp++;
                    if (host_data !== e.data) begin
                        n_bad++;
                        $display("FAIL %s host_data actual=%h expected=%h", e.req, host_data, e.data);
                    end
                end
            end
        end
    end

    task automatic set_cmd(input logic [2:0] c);
        @(negedge clk);
        host_cmd = c;
        repeat (5) @(negedge clk);
        m_grp = c[1:0];
        if (c[2]) m_addr = '0;
    endtask

    task automatic strobe_pulse();
        @(negedge clk);
        host_strobe = 1'b1;
        repeat (SETTLE) @(negedge clk);
        if (m_grp != 2'd0) begin
            m_data = pat(m_grp, m_addr);
            m_addr = m_addr + 1'b1;
        end
        host_strobe = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        push_exp("R1 reset state");

        set_cmd(3'b001);
        push_exp("R2 R3 group 0 selected");
        strobe_pulse();
        push_exp("R5 R6 first word, falling edge ignored");
        for (int i = 0; i < 3; i++) begin
            strobe_pulse();
            push_exp("R5 sequential read group 0");
        end

        set_cmd(3'b010);
        push_exp("R10 R2 group 1 keeps address");
        strobe_pulse();
        push_exp("R5 read group 1");

        set_cmd(3'b011);
        push_exp("R10 R2 group 2 keeps address");
        strobe_pulse();
        push_exp("R5 read group 2");

        // short glitch below the debounce length
        @(negedge clk);
        host_strobe = 1'b1;
        repeat (DEB_CYC - 2) @(negedge clk);
        host_strobe = 1'b0;
        repeat (SETTLE) @(negedge clk);
        push_exp("R4 glitch ignored");

        set_cmd(3'b000);
        push_exp("R2 R3 no group, buffer off");
        strobe_pulse();
        push_exp("R6 edge outside read mode ignored");

        set_cmd(3'b100);
        push_exp("R7 rewind while idle");

        set_cmd(3'b001);
        for (int i = 0; i < (1 << ADDR_W) - 1; i++) strobe_pulse();
        push_exp("R9 address at top");
        strobe_pulse();
        push_exp("R9 address wrapped");

        for (int i = 0; i < 3; i++) strobe_pulse();
        push_exp("R5 before coincidence");

        // rewind pulse timed to land with the accepted edge
        @(negedge clk);
        host_strobe = 1'b1;
        repeat (DEB_CYC) @(negedge clk);
        host_cmd = 3'b101;
        @(negedge clk);
        host_cmd = 3'b001;
        repeat (SETTLE) @(negedge clk);
        m_data = pat(2'd1, m_addr);
        m_addr = '0;
        host_strobe = 1'b0;
        repeat (SETTLE) @(negedge clk);
        push_exp("R8 rewind and edge together");

        strobe_pulse();
        push_exp("R8 R5 read resumes from zero");

        repeat (4) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule